// File: doc/BRIEF.md
# Register Bit-Attribute Checker

This block walks a fixed table of 16-bit registers and confirms that every tested bit behaves as its declared attribute says. Each table entry names a register offset, a mask of bits that must never change (read-only) and a mask of bits that must follow whatever is written (read/write). For every entry the checker reads the register's current contents, writes the test bits low and reads back, writes the test bits high and reads back, and finally writes the saved contents back.

The block is a bus master on a simple synchronous register port with one-cycle read latency. A `start` pulse launches a run. The run ends at the first failing readback or after the last entry. The outcome stays on the status outputs until the next `start`: a pass flag, a failure kind, the failing offset and the mask of offending bits. The table is a built-in constant lookup with five entries, at offsets 0x00, 0x02, 0x04, 0x07 and 0x10.

Top module: `regattr_checker`

## Requirements
- R1: After reset, `busy`, `done`, `pass`, `bus_rd` and `bus_wr` are low, and `err_code`, `err_offset` and `err_mask` are zero.
- R2: A `start` pulse walks the entries in table order: offset 0x00 (read-only 0x0000, read/write 0x7180), 0x02 (0xFFFF, 0x0000), 0x04 (0x0000, 0xFFFF), 0x07 (0x0800, 0xB7FF) and 0x10 (0x0000, 0xFFBF). Each entry issues, one per cycle of activity, read, write, read, write, read and write, all at the entry's offset. Read data is taken in the cycle after `bus_rd`, and `bus_rd` and `bus_wr` are never both high.
- R3: The first write of an entry carries the saved value with every bit of (read-only OR read/write) cleared, and bits in neither mask keep their saved value.
- R4: The second write of an entry carries the saved value with every bit of (read-only OR read/write) set.
- R5: A read-only bit that differs from its saved value after the first write ends the run with `err_code` 1. Read-only failures take priority over read/write failures found in the same readback.
- R6: A read-only bit that differs from its saved value after the second write ends the run with `err_code` 2.
- R7: A read/write bit that reads back 1 after the first write ends the run with `err_code` 3.
- R8: A read/write bit that reads back 0 after the second write ends the run with `err_code` 4.
- R9: On a failure, no further test write is made for that entry. The saved value is still written back, and then the run stops with `done` high and `pass` low. `err_offset` holds the entry's offset and `err_mask` holds exactly the failing bits of the failing kind.
- R10: When every entry passes, the final write restores the last entry's saved value, and `done` and `pass` go high with `err_code` and `err_mask` zero.
- R11: Bits in neither mask are never compared, so a change in them on readback causes no failure.
- R12: `done` and the status outputs hold, with no bus activity, until the next `start`. That `start` clears the status and reruns from the first entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a run (idle or finished state only) |
| bus_rd | output | 1 | Read strobe; data expected on `bus_rdata` next cycle |
| bus_wr | output | 1 | Write strobe |
| bus_addr | output | 5 | Register offset |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, one cycle after `bus_rd` |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, status valid |
| pass | output | 1 | Finished with no failure |
| err_code | output | 3 | 0 none, 1 RO changed on zero pass, 2 RO changed on one pass, 3 RW not cleared, 4 RW not set |
| err_offset | output | 5 | Offset of the failing entry |
| err_mask | output | 16 | Failing bits |

## Verification
A wrong saved value shows on the bus within two cycles, as a wrong first write data, and again as a wrong restore write. A wrong entry index or state shows at once, as an out-of-order address or operation kind on the next strobe. Every bus transaction is compared, in order, against a sequence the bench predicts from its own register model. A mis-latched failure kind, offset or mask is visible on the status outputs as soon as `done` rises.

// File: rtl/regattr_pkg.sv
package regattr_pkg;
  localparam int DW        = 16;
  localparam int AW        = 5;
  localparam int N_ENTRIES = 5;
  localparam int IDX_W     = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

  typedef struct packed {
    logic [AW-1:0] off;
    logic [DW-1:0] ro;
    logic [DW-1:0] rw;
  } entry_t;

  typedef enum logic [2:0] {
    E_NONE    = 3'd0,
    E_RO_ZERO = 3'd1,
    E_RO_ONE  = 3'd2,
    E_RW_CLR  = 3'd3,
    E_RW_SET  = 3'd4
  } err_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_ORIG, S_CAP, S_WR0, S_RD0, S_CMP0,
    S_WR1, S_RD1, S_CMP1, S_REST, S_FIN
  } state_e;
endpackage

// File: rtl/regattr_rom.sv
module regattr_rom
  import regattr_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  output entry_t           ent
);
  always_comb begin
    case (idx)
      IDX_W'(0): ent = '{off: AW'(5'h00), ro: DW'(16'h0000), rw: DW'(16'h7180)};
      IDX_W'(1): ent = '{off: AW'(5'h02), ro: DW'(16'hFFFF), rw: DW'(16'h0000)};
      IDX_W'(2): ent = '{off: AW'(5'h04), ro: DW'(16'h0000), rw: DW'(16'hFFFF)};
      IDX_W'(3): ent = '{off: AW'(5'h07), ro: DW'(16'h0800), rw: DW'(16'hB7FF)};
      IDX_W'(4): ent = '{off: AW'(5'h10), ro: DW'(16'h0000), rw: DW'(16'hFFBF)};
      default:   ent = '{off: '0, ro: '0, rw: '0};
    endcase
  end
endmodule

// File: rtl/regattr_cmp.sv
module regattr_cmp
  import regattr_pkg::*;
(
  input  logic          one_pass,
  input  logic [DW-1:0] orig,
  input  logic [DW-1:0] rdata,
  input  logic [DW-1:0] ro_mask,
  input  logic [DW-1:0] rw_mask,
  output err_e          code,
  output logic [DW-1:0] bad_mask
);
  logic [DW-1:0] ro_bad;
  logic [DW-1:0] rw_bad;

  always_comb begin
    ro_bad = (rdata ^ orig) & ro_mask;
    rw_bad = one_pass ? (~rdata & rw_mask) : (rdata & rw_mask);
    if (|ro_bad) begin
      code     = one_pass ? E_RO_ONE : E_RO_ZERO;
      bad_mask = ro_bad;
    end else if (|rw_bad) begin
      code     = one_pass ? E_RW_SET : E_RW_CLR;
      bad_mask = rw_bad;
    end else begin
      code     = E_NONE;
      bad_mask = '0;
    end
  end
endmodule

// File: rtl/regattr_seq.sv
module regattr_seq
  import regattr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  entry_t           ent,
  input  logic [DW-1:0]    rdata,
  input  err_e             cmp_code,
  input  logic [DW-1:0]    cmp_mask,
  output logic [IDX_W-1:0] idx,
  output logic             one_pass,
  output logic [DW-1:0]    orig,
  output logic             bus_rd,
  output logic             bus_wr,
  output logic [AW-1:0]    bus_addr,
  output logic [DW-1:0]    bus_wdata,
  output logic             busy,
  output logic             done,
  output err_e             err_code,
  output logic [AW-1:0]    err_offset,
  output logic [DW-1:0]    err_mask
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRIES - 1);

  state_e           state, state_n;
  logic             idx_en, orig_en, err_en, launch, cmp_now, failed;
  logic [IDX_W-1:0] idx_n;
  logic [DW-1:0]    test_bits;

  assign test_bits = ent.ro | ent.rw;
  assign launch    = start && (state == S_IDLE || state == S_FIN);
  assign cmp_now   = (state == S_CMP0 || state == S_CMP1);
  assign failed    = (err_code != E_NONE);

  always_comb begin
    state_n = state;
    idx_n   = idx;
    idx_en  = 1'b0;
    case (state)
      S_IDLE, S_FIN: if (launch) begin
        state_n = S_RD_ORIG;
        idx_n   = '0;
        idx_en  = 1'b1;
      end
      S_RD_ORIG: state_n = S_CAP;
      S_CAP:     state_n = S_WR0;
      S_WR0:     state_n = S_RD0;
      S_RD0:     state_n = S_CMP0;
      S_CMP0:    state_n = (cmp_code != E_NONE) ? S_REST : S_WR1;
      S_WR1:     state_n = S_RD1;
      S_RD1:     state_n = S_CMP1;
      S_CMP1:    state_n = S_REST;
      S_REST: begin
        if (failed || idx == LAST) begin
          state_n = S_FIN;
        end else begin
          state_n = S_RD_ORIG;
          idx_n   = idx + 1'b1;
          idx_en  = 1'b1;
        end
      end
      default:   state_n = S_IDLE;
    endcase
  end

  assign orig_en = (state == S_CAP);
  assign err_en  = launch || (cmp_now && cmp_code != E_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      idx        <= '0;
      orig       <= '0;
      err_code   <= E_NONE;
      err_offset <= '0;
      err_mask   <= '0;
    end else begin
      state <= state_n;
      if (idx_en)  idx  <= idx_n;
      if (orig_en) orig <= rdata;
      if (err_en) begin
        err_code   <= launch ? E_NONE : cmp_code;
        err_offset <= launch ? '0 : ent.off;
        err_mask   <= launch ? '0 : cmp_mask;
      end
    end
  end

  always_comb begin
    one_pass  = (state == S_CMP1);
    bus_rd    = (state == S_RD_ORIG || state == S_RD0 || state == S_RD1);
    bus_wr    = (state == S_WR0 || state == S_WR1 || state == S_REST);
    bus_addr  = (bus_rd || bus_wr) ? ent.off : '0;
    case (state)
      S_WR0:   bus_wdata = orig & ~test_bits;
      S_WR1:   bus_wdata = orig | test_bits;
      S_REST:  bus_wdata = orig;
      default: bus_wdata = '0;
    endcase
    busy = !(state == S_IDLE || state == S_FIN);
    done = (state == S_FIN);
  end
endmodule

// File: rtl/regattr_checker.sv
module regattr_checker
  import regattr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [4:0]    bus_addr,
  output logic [15:0]   bus_wdata,
  input  logic [15:0]   bus_rdata,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic [2:0]    err_code,
  output logic [4:0]    err_offset,
  output logic [15:0]   err_mask
);
  logic [IDX_W-1:0] idx;
  entry_t           ent;
  logic             one_pass;
  logic [DW-1:0]    orig;
  err_e             cmp_code;
  logic [DW-1:0]    cmp_mask;
  err_e             err_q;

  regattr_rom u_rom (.idx(idx), .ent(ent));

  regattr_cmp u_cmp (
    .one_pass(one_pass), .orig(orig), .rdata(bus_rdata),
    .ro_mask(ent.ro), .rw_mask(ent.rw),
    .code(cmp_code), .bad_mask(cmp_mask)
  );

  regattr_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .ent(ent), .rdata(bus_rdata),
    .cmp_code(cmp_code), .cmp_mask(cmp_mask), .idx(idx), .one_pass(one_pass),
    .orig(orig), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .busy(busy), .done(done), .err_code(err_q),
    .err_offset(err_offset), .err_mask(err_mask)
  );

  assign err_code = err_q;
  assign pass     = done && (err_q == E_NONE);
endmodule

// File: rtl/regattr_checker_sva.sv
module regattr_checker_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic        busy,
  input logic        done,
  input logic        pass,
  input logic [2:0]  err_code,
  input logic [4:0]  err_offset,
  input logic [15:0] err_mask
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_rd && !bus_wr));

  a_r2_single_op: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  a_r9_restore_before_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(bus_wr));

  a_r9_fail_report: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !pass) |-> (err_code >= 3'd1 && err_code <= 3'd4 && err_mask != 16'h0));

  a_r10_pass_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pass) |-> (err_code == 3'd0 && err_mask == 16'h0));

  a_r12_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(err_code) && $stable(err_offset) && $stable(err_mask)));
endmodule

bind regattr_checker regattr_checker_sva u_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .busy(busy), .done(done), .pass(pass), .err_code(err_code),
  .err_offset(err_offset), .err_mask(err_mask)
);

// File: tb/sim_regattr_checker.sv
`timescale 1ns/1ps
module sim_regattr_checker;
  typedef struct {
    bit          we;
    logic [4:0]  a;
    logic [15:0] d;
  } txn_t;

  logic        clk, rst_n, start;
  logic        bus_rd, bus_wr, busy, done, pass;
  logic [4:0]  bus_addr, err_offset;
  logic [15:0] bus_wdata, bus_rdata, err_mask;
  logic [2:0]  err_code;

  int checks = 0, fails = 0, mchecks = 0, mfails = 0;
  bit finished = 0;
  txn_t q[$];

  logic [15:0] m_reg[32], m_init[32], m_wm[32], m_st0[32], m_st1[32], m_flip[32];
  bit          m_wr[32];
  logic        model_load;

  logic [4:0]  t_off[5] = '{5'h00, 5'h02, 5'h04, 5'h07, 5'h10};
  logic [15:0] t_ro[5]  = '{16'h0000, 16'hFFFF, 16'h0000, 16'h0800, 16'h0000};
  logic [15:0] t_rw[5]  = '{16'h7180, 16'h0000, 16'hFFFF, 16'hB7FF, 16'hFFBF};

  regattr_checker u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .done(done), .pass(pass), .err_code(err_code),
    .err_offset(err_offset), .err_mask(err_mask)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  function automatic logic [15:0] rd_val(logic [15:0] r, int a, bit w);
    return ((r & ~m_st0[a]) | m_st1[a]) ^ (w ? m_flip[a] : 16'h0);
  endfunction

  // register model behind the bus port, one-cycle read latency
  always @(posedge clk) begin
    if (model_load) begin
      for (int i = 0; i < 32; i++) begin
        m_reg[i] <= m_init[i];
        m_wr[i]  <= 0;
      end
    end else begin
      if (bus_wr) begin
        m_reg[bus_addr] <= (bus_wdata & m_wm[bus_addr]) | (m_reg[bus_addr] & ~m_wm[bus_addr]);
        m_wr[bus_addr]  <= 1;
      end
      if (bus_rd) bus_rdata <= rd_val(m_reg[bus_addr], bus_addr, m_wr[bus_addr]);
    end
  end

  // monitor: pops the predicted transaction for each strobe
  always @(negedge clk) begin
    if (rst_n && (bus_rd || bus_wr)) begin
      mchecks++;
      if (q.size() == 0) begin
        mfails++;
        $display("FAIL R2/R9: unexpected bus op we=%0b addr=%h data=%h, expected none",
                 bus_wr, bus_addr, bus_wdata);
      end else begin
        txn_t e;
        e = q.pop_front();
        if (e.we != bus_wr || e.a != bus_addr || (e.we && e.d != bus_wdata)) begin
          mfails++;
          $display("FAIL R2/R3/R4/R9: bus op got we=%0b addr=%h data=%h, expected we=%0b addr=%h data=%h",
                   bus_wr, bus_addr, bus_wdata, e.we, e.a, e.d);
        end
      end
    end
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cfg_default();
    for (int i = 0; i < 32; i++) begin
      m_init[i] = 16'h0; m_wm[i] = 16'h0; m_st0[i] = 16'h0;
      m_st1[i] = 16'h0; m_flip[i] = 16'h0;
    end
    m_init[5'h00] = 16'h1234; m_init[5'h02] = 16'hA5C3; m_init[5'h04] = 16'h0F0F;
    m_init[5'h07] = 16'h4C21; m_init[5'h10] = 16'h8041;
    for (int k = 0; k < 5; k++) m_wm[t_off[k]] = t_rw[k];
    m_flip[5'h07] = 16'h4000;  // R11: untested bit toggles on readback
    m_flip[5'h10] = 16'h0040;
  endtask

  // predicts the bus sequence and outcome from the requirements
  task automatic run(string name, logic [2:0] exp_code, logic [4:0] exp_off, logic [15:0] exp_mask);
    logic [15:0] r[32];
    logic [2:0]  pc = 0;
    logic [4:0]  po = 0;
    logic [15:0] pm = 0;
    int          wd = 0;
    for (int i = 0; i < 32; i++) r[i] = m_init[i];
    for (int k = 0; k < 5 && pc == 0; k++) begin
      int a = t_off[k];
      logic [15:0] tb = t_ro[k] | t_rw[k];
      logic [15:0] orig, w, rb, rob, rwb;
      orig = rd_val(r[a], a, 0);
      q.push_back('{0, t_off[k], 16'h0});
      w = orig & ~tb;
      q.push_back('{1, t_off[k], w});
      r[a] = (w & m_wm[a]) | (r[a] & ~m_wm[a]);
      q.push_back('{0, t_off[k], 16'h0});
      rb = rd_val(r[a], a, 1);
      rob = (rb ^ orig) & t_ro[k]; rwb = rb & t_rw[k];
      if (rob != 0) begin pc = 1; pm = rob; po = t_off[k]; end
      else if (rwb != 0) begin pc = 3; pm = rwb; po = t_off[k]; end
      if (pc == 0) begin
        w = orig | tb;
        q.push_back('{1, t_off[k], w});
        r[a] = (w & m_wm[a]) | (r[a] & ~m_wm[a]);
        q.push_back('{0, t_off[k], 16'h0});
        rb = rd_val(r[a], a, 1);
        rob = (rb ^ orig) & t_ro[k]; rwb = ~rb & t_rw[k];
        if (rob != 0) begin pc = 2; pm = rob; po = t_off[k]; end
        else if (rwb != 0) begin pc = 4; pm = rwb; po = t_off[k]; end
      end
      q.push_back('{1, t_off[k], orig});
      r[a] = (orig & m_wm[a]) | (r[a] & ~m_wm[a]);
    end
    chk({name, " predicted code"}, pc, exp_code);
    @(negedge clk); model_load = 1;
    @(negedge clk); model_load = 0; start = 1;
    @(negedge clk); start = 0;
    chk({name, " R12 status cleared on start"}, {busy, err_code}, {1'b1, 3'd0});
    while (!done && wd < 500) begin @(negedge clk); wd++; end
    chk({name, " done"}, done, 1'b1);
    chk({name, " pass"}, pass, (pc == 0));
    chk({name, " err_code"}, err_code, pc);
    chk({name, " err_offset"}, err_offset, po);
    chk({name, " err_mask"}, err_mask, pm);
    chk({name, " R2/R9 all predicted ops seen"}, q.size(), 0);
    q.delete();
  endtask

  initial begin
    rst_n = 0; start = 0; model_load = 0;
    cfg_default();
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {busy, done, pass, bus_rd, bus_wr, err_code, err_offset, err_mask},
        {5'b0, 3'd0, 5'd0, 16'h0});
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle after reset", {busy, done, bus_rd, bus_wr}, 4'b0);

    cfg_default();
    run("R10/R11/R3/R4 all pass", 3'd0, 5'd0, 16'h0);
    repeat (6) @(negedge clk);
    chk("R12 done held", {done, pass, bus_rd, bus_wr}, 4'b1100);

    cfg_default(); m_wm[5'h07] = m_wm[5'h07] | 16'h0800; m_st1[5'h07] = 16'h0001;
    run("R5 RO changed on zero pass, priority over RW", 3'd1, 5'h07, 16'h0800);

    cfg_default(); m_wm[5'h07] = m_wm[5'h07] | 16'h0800; m_init[5'h07] = 16'h4421;
    run("R6 RO changed on one pass", 3'd2, 5'h07, 16'h0800);

    cfg_default(); m_st1[5'h00] = 16'h0100;
    run("R7 RW not cleared", 3'd3, 5'h00, 16'h0100);

    cfg_default(); m_st0[5'h04] = 16'h0008;
    run("R8 RW not set", 3'd4, 5'h04, 16'h0008);
    repeat (4) @(negedge clk);
    chk("R9 R12 stopped after failure", {done, busy, bus_rd, bus_wr}, 4'b1000);

    finished = 1;
    checks += mchecks; fails += mfails;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks += mchecks + 1; fails += mfails + 1;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule